// File: doc/BRIEF.md
# I2C Clock-Output Enable Register Slave

This block is the control port of a clock fanout device. A single reference clock is copied onto a set of buffered outputs. Each output has its own enable bit, and a two-wire serial bus slave loads these bits. The slave works at standard-mode bit rates. It samples SCL and SDA on a much faster system clock and pulls SDA low through an open-drain output enable.

The slave does not keep a register-address pointer. After a matching address with the write direction, it acknowledges and drops two leading bytes: a command code and a byte count. The bytes that follow go into enable byte 0, then byte 1, and so on, until a STOP ends the transfer. A read always starts at byte 0. While the active-low power-down input is low, the slave lets go of the bus and keeps every stored bit.

Each clock output is gated so that an enable change takes effect only on a falling edge of the reference clock. Because of this, no output ever produces a shortened pulse.

Top module: `clken_fanout_top`

## Requirements
- R1: A transfer that begins with START and the 7-bit address DEV_ADDR (default 0x69) followed by direction bit 0 is acknowledged. Every later byte of the write is also acknowledged. The slave acknowledges by holding SDA low during the ninth SCL pulse.
- R2: In a write, the first two bytes after the address are acknowledged and then discarded, whatever their values. Neither byte changes any enable bit.
- R3: Data bytes after those two go into enable byte 0, byte 1 and byte 2, in that order, until STOP. Bit k of enable byte b controls clk_out[8*b+k].
- R4: If STOP arrives partway through a byte, no enable bit changes because of the partial byte. Complete bytes received earlier in the same transfer keep their new values.
- R5: A read (address followed by direction bit 1) returns enable byte 0, then byte 1, then byte 2, sending each byte MSB first. The read goes on while the master acknowledges. A master NACK ends it.
- R6: After reset, every bit of all three enable bytes is 1.
- R7: An output whose enable bit is 1 follows ref_clk. An output whose enable bit is 0 stays low. A change of an enable bit takes effect only at a falling edge of ref_clk, so an output never has a partial high pulse.
- R8: Write data bytes past the last enable byte are acknowledged and discarded. Read bytes past the last enable byte return 0xFF.
- R9: If the address after START does not match, the slave does not acknowledge it. The slave then ignores the bus until the next START.
- R10: While pd_n is low, the slave never pulls SDA and ignores SCL. When pd_n returns high, the enable bits hold the values they had before power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| scl_i | input | 1 | Serial bus clock as seen on the pin |
| sda_i | input | 1 | Serial bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| ref_clk | input | 1 | Reference clock copied onto the outputs |
| clk_out | output | NOUT (24) | Gated copies of ref_clk, one per enable bit |

## Verification
Two situations are hard to reach from the ports. The first is a STOP that cuts a byte short. The bench reaches it with a write that sends one complete data byte, then four bits of a second byte, then a STOP, and afterwards reads the enable bytes back.

The second is an enable bit that falls while ref_clk is high. The reference clock runs free with a half period that shares no timing with the bus. Register updates therefore land at many different phases of ref_clk. A monitor samples every output on each system clock and flags two faults: any high output while ref_clk is low, and any change of an output in the middle of a ref_clk high phase.

// File: rtl/clken_pkg.sv
package clken_pkg;

    // Receive/transmit states of the serial slave
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_st_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/clken_bus_sync.sv
module clken_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic pd_n,
    output logic scl_s,
    output logic sda_s,
    output logic pd_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start,
    output logic stop
);

    typedef struct packed {
        logic [STAGES-1:0] scl_ff;
        logic [STAGES-1:0] sda_ff;
        logic [STAGES-1:0] pd_ff;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_ff   = {sync_q.scl_ff[STAGES-2:0], scl_i};
        sync_d.sda_ff   = {sync_q.sda_ff[STAGES-2:0], sda_i};
        sync_d.pd_ff    = {sync_q.pd_ff[STAGES-2:0], pd_n};
        sync_d.scl_prev = sync_q.scl_ff[STAGES-1];
        sync_d.sda_prev = sync_q.sda_ff[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.scl_ff   <= '1;
            sync_q.sda_ff   <= '1;
            sync_q.pd_ff    <= '0;
            sync_q.scl_prev <= 1'b1;
            sync_q.sda_prev <= 1'b1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_s    = sync_q.scl_ff[STAGES-1];
    assign sda_s    = sync_q.sda_ff[STAGES-1];
    assign pd_s     = sync_q.pd_ff[STAGES-1];
    assign scl_rise = scl_s & ~sync_q.scl_prev;
    assign scl_fall = ~scl_s & sync_q.scl_prev;
    assign start    = scl_s & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop     = scl_s & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

endmodule

// File: rtl/clken_i2c_ctrl.sv
module clken_i2c_ctrl
    import clken_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         NUM_BYTES = 3,
    parameter int         CNTW      = $clog2(NUM_BYTES + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_s,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start,
    input  logic              stop,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [CNTW-1:0]   rd_idx,
    output logic              wr_en,
    output logic [CNTW-1:0]   wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              oe
);

    localparam logic [CNTW-1:0] CNT_DAT0 = CNTW'(2);
    localparam logic [CNTW-1:0] CNT_LAST = CNTW'(NUM_BYTES + 2);

    typedef struct packed {
        bus_st_e           st;
        logic [BYTE_W-1:0] sh;
        logic [3:0]        bitc;
        logic              rw;
        logic              addr_ph;
        logic              ackd;
        logic [CNTW-1:0]   bcnt;
        logic              oe;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{st: ST_IDLE, sh: '0, bitc: '0, rw: 1'b0,
                                   addr_ph: 1'b0, ackd: 1'b0, bcnt: '0, oe: 1'b0};

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        wr_en  = 1'b0;
        if (!pd_s) begin
            ctrl_d = CTRL_RST;
        end else if (start) begin
            ctrl_d.st      = ST_RX;
            ctrl_d.addr_ph = 1'b1;
            ctrl_d.bitc    = '0;
            ctrl_d.bcnt    = '0;
            ctrl_d.oe      = 1'b0;
        end else if (stop) begin
            ctrl_d.st = ST_IDLE;
            ctrl_d.oe = 1'b0;
        end else begin
            unique case (ctrl_q.st)
                ST_IDLE: ;
                ST_RX: begin
                    if (scl_rise) begin
                        ctrl_d.sh   = {ctrl_q.sh[BYTE_W-2:0], sda_s};
                        ctrl_d.bitc = ctrl_q.bitc + 4'd1;
                    end else if (scl_fall && ctrl_q.bitc == 4'd8) begin
                        if (ctrl_q.addr_ph) begin
                            if (ctrl_q.sh[7:1] == DEV_ADDR) begin
                                ctrl_d.rw = ctrl_q.sh[0];
                                ctrl_d.st = ST_RX_ACK;
                                ctrl_d.oe = 1'b1;
                            end else begin
                                ctrl_d.st = ST_IDLE;
                            end
                        end else begin
                            ctrl_d.st = ST_RX_ACK;
                            ctrl_d.oe = 1'b1;
                            if (ctrl_q.bcnt >= CNT_DAT0 && ctrl_q.bcnt < CNT_LAST)
                                wr_en = 1'b1;
                            if (ctrl_q.bcnt != CNT_LAST)
                                ctrl_d.bcnt = ctrl_q.bcnt + CNTW'(1);
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        ctrl_d.oe      = 1'b0;
                        ctrl_d.bitc    = '0;
                        ctrl_d.addr_ph = 1'b0;
                        if (ctrl_q.addr_ph && ctrl_q.rw) begin
                            ctrl_d.st = ST_TX;
                            ctrl_d.sh = rd_byte;
                            ctrl_d.oe = ~rd_byte[7];
                        end else begin
                            ctrl_d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (ctrl_q.bitc == 4'd7) begin
                            ctrl_d.st   = ST_TX_ACK;
                            ctrl_d.oe   = 1'b0;
                            ctrl_d.ackd = 1'b0;
                        end else begin
                            ctrl_d.sh   = {ctrl_q.sh[BYTE_W-2:0], 1'b0};
                            ctrl_d.oe   = ~ctrl_q.sh[6];
                            ctrl_d.bitc = ctrl_q.bitc + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            ctrl_d.st = ST_IDLE;
                        end else begin
                            ctrl_d.ackd = 1'b1;
                            if (ctrl_q.bcnt != CNT_LAST)
                                ctrl_d.bcnt = ctrl_q.bcnt + CNTW'(1);
                        end
                    end else if (scl_fall && ctrl_q.ackd) begin
                        ctrl_d.st   = ST_TX;
                        ctrl_d.bitc = '0;
                        ctrl_d.sh   = rd_byte;
                        ctrl_d.oe   = ~rd_byte[7];
                    end
                end
                default: ctrl_d = CTRL_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else        ctrl_q <= ctrl_d;
    end

    assign rd_idx  = ctrl_q.bcnt;
    assign wr_idx  = ctrl_q.bcnt - CNT_DAT0;
    assign wr_data = ctrl_q.sh;
    assign oe      = ctrl_q.oe;

    // R1
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.oe) |-> !scl_s);

    // R10
    pd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_s |=> !ctrl_q.oe);

    // R2
    wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ctrl_q.bcnt >= CNT_DAT0) && !ctrl_q.rw && !ctrl_q.addr_ph);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_IDLE) |-> !ctrl_q.oe);

endmodule

// File: rtl/clken_gate_bank.sv
module clken_gate_bank #(
    parameter int NOUT = 24
) (
    input  logic            rst_n,
    input  logic            ref_clk,
    input  logic [NOUT-1:0] en,
    output logic [NOUT-1:0] clk_out
);

    logic [NOUT-1:0] gate_d, gate_q;

    always_comb gate_d = en;

    for (genvar i = 0; i < NOUT; i++) begin : g_gate
        always_ff @(negedge ref_clk or negedge rst_n) begin
            if (!rst_n) gate_q[i] <= 1'b1;
            else        gate_q[i] <= gate_d[i];
        end
        assign clk_out[i] = ref_clk & gate_q[i];
    end

endmodule

// File: rtl/clken_fanout_top.sv
module clken_fanout_top
    import clken_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         NUM_BYTES = 3,
    parameter int         NOUT      = NUM_BYTES * BYTE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pd_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe,
    input  logic            ref_clk,
    output logic [NOUT-1:0] clk_out
);

    localparam int CNTW = $clog2(NUM_BYTES + 3);

    logic              scl_s, sda_s, pd_s;
    logic              scl_rise, scl_fall, start, stop;
    logic [CNTW-1:0]   rd_idx, wr_idx;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data, rd_byte;

    logic [NUM_BYTES-1:0][BYTE_W-1:0] regs_d, regs_q;

    clken_bus_sync #(.STAGES(2)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .pd_n     (pd_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .pd_s     (pd_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start    (start),
        .stop     (stop)
    );

    clken_i2c_ctrl #(
        .DEV_ADDR  (DEV_ADDR),
        .NUM_BYTES (NUM_BYTES),
        .CNTW      (CNTW)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_s     (pd_s),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start    (start),
        .stop     (stop),
        .rd_byte  (rd_byte),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .oe       (sda_oe)
    );

    always_comb begin
        regs_d = regs_q;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (wr_en && wr_idx == CNTW'(b)) regs_d[b] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '1;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_byte = '1;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (rd_idx == CNTW'(b)) rd_byte = regs_q[b];
        end
    end

    clken_gate_bank #(.NOUT(NOUT)) i_gate (
        .rst_n   (rst_n),
        .ref_clk (ref_clk),
        .en      (regs_q),
        .clk_out (clk_out)
    );

    // R8
    wr_idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < CNTW'(NUM_BYTES)));

endmodule

// File: tb/test_clken_fanout_top.sv
module test_clken_fanout_top;

    localparam logic [6:0] ADDR = 7'h69;
    localparam int NOUT = 24;
    localparam int Q    = 10;
    localparam int WD   = 150000;

    logic clk = 1'b0;
    logic rst_n, pd_n, scl_m, sda_m, ref_clk;
    logic sda_oe, sda_line;
    logic [NOUT-1:0] clk_out;
    int n_chk = 0, n_fail = 0, n_viol = 0;

    assign sda_line = sda_m & ~sda_oe;

    clken_fanout_top i_clken_fanout_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .ref_clk (ref_clk),
        .clk_out (clk_out)
    );

    always #2 clk = ~clk;

    initial begin
        ref_clk = 1'b0;
        #3;
        forever #16 ref_clk = ~ref_clk;
    end

    typedef struct packed {
        logic [2:0]  nb;
        logic [31:0] dat;
        logic [23:0] exp;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{3'd3, 32'h000F3CA5, 24'h0F3CA5},
        '{3'd1, 32'h00000000, 24'h0F3C00},
        '{3'd4, 32'h44332211, 24'h332211},
        '{3'd2, 32'h00000180, 24'h330180},
        '{3'd0, 32'h00000000, 24'h330180}
    };

    // R7 runt monitor: no high output while ref_clk low, no change mid-high
    logic            ref_prev = 1'b0;
    logic [NOUT-1:0] out_prev = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NOUT; i++) begin
                if ((!ref_clk && clk_out[i]) ||
                    (ref_clk && ref_prev && clk_out[i] != out_prev[i]))
                    n_viol++;
            end
        end
        ref_prev = ref_clk;
        out_prev = clk_out;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = ~sda_line;
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq();
            b[i] = sda_line;
            scl_m = 1'b0;
        end
        wq();
        sda_m = ~give_ack; wq();
        scl_m = 1'b1; wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic write_txn(input logic [2:0] nb, input logic [31:0] dat,
                             input logic [7:0] cmd, input logic exp_ack);
        logic ack;
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        check(exp_ack ? "R1 address ack" : "R10/R9 address no ack", 32'(ack), 32'(exp_ack));
        send_byte(cmd, ack);
        check("R2 command byte ack", 32'(ack), 32'(exp_ack));
        send_byte({5'd0, nb}, ack);
        check("R2 count byte ack", 32'(ack), 32'(exp_ack));
        for (int i = 0; i < int'(nb); i++) begin
            send_byte(dat[8*i +: 8], ack);
            check(i < 3 ? "R3 data ack" : "R8 extra data ack", 32'(ack), 32'(exp_ack));
        end
        bus_stop();
    endtask

    task automatic read_all(input string req, input logic [23:0] exp);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        check("R1 read address ack", 32'(ack), 32'd1);
        for (int i = 0; i < 3; i++) begin
            recv_byte(1'b1, b);
            check(req, 32'(b), 32'(exp[8*i +: 8]));
        end
        recv_byte(1'b0, b);
        check("R8 read past end is FF", 32'(b), 32'hFF);
        bus_stop();
    endtask

    task automatic check_outputs(input string req, input logic [23:0] exp);
        @(posedge ref_clk); #2;
        check(req, 32'(clk_out), 32'(exp));
        @(negedge ref_clk); #2;
        check("R7 outputs low while ref_clk low", 32'(clk_out), 32'd0);
    endtask

    initial begin
        logic ack;
        rst_n = 1'b0; pd_n = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R6: reset state visible on outputs and by readback
        check_outputs("R6 reset enables all ones", 24'hFFFFFF);
        read_all("R6 reset readback", 24'hFFFFFF);

        // Table of block writes (R2, R3, R5, R8)
        for (int v = 0; v < NV; v++) begin
            write_txn(VEC[v].nb, VEC[v].dat, (v == 4) ? 8'hFF : 8'h5A, 1'b1);
            repeat (20) @(negedge clk);
            read_all("R5 readback after write", VEC[v].exp);
            check_outputs("R3/R7 outputs follow enables", VEC[v].exp);
        end

        // R4: stop after four bits of the second data byte
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h00, ack);
        send_byte(8'h02, ack);
        send_byte(8'h77, ack);
        check("R4 full byte ack", 32'(ack), 32'd1);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_stop();
        read_all("R4 partial byte discarded", 24'h330177);

        // R9: non-matching address, following bytes ignored
        bus_start();
        send_byte({7'h12, 1'b0}, ack);
        check("R9 foreign address no ack", 32'(ack), 32'd0);
        send_byte(8'h00, ack);
        check("R9 bus ignored after mismatch", 32'(ack), 32'd0);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        bus_stop();
        read_all("R9 enables unchanged", 24'h330177);

        // R10: power-down releases bus, keeps enables
        pd_n = 1'b0;
        repeat (10) @(negedge clk);
        write_txn(3'd3, 32'h00000000, 8'h00, 1'b0);
        check_outputs("R10 enables kept in power-down", 24'h330177);
        pd_n = 1'b1;
        repeat (10) @(negedge clk);
        read_all("R10 enables kept after power-down", 24'h330177);

        check("R7 no runt pulse on any output", 32'(n_viol), 32'd0);

        summary();
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule